// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block decides whether a vector instruction that has already been decoded may be issued. It takes the instruction's vector register numbers and a few class flags from the decoder: vset, memory access, widening, narrowing, sign-extension factor, mask-writing and masked. It also takes the vector type state (`vill`, SEW, LMUL) and the current `vstart` value. It returns one flag, `illegal_o`. That flag is the OR of eight independent categories:

- reserved encoding
- `vill` set
- nonzero `vstart`
- element-width error
- effective-LMUL error
- register-group misalignment
- mask-register overlap
- source/destination group overlap

A vset instruction is exempt from every category except the reserved-encoding one. A memory access is exempt from the `vstart` rule. The parameter `REG_OUT` selects a registered output, which is the default, or a purely combinational output. The decoder feeds the block once per instruction and folds the flag into its illegal-instruction exception.

Top module: `vec_legal_chk`

## Requirements
- R1: When `reserved_i` is 1, `illegal_o` is 1. This holds for every other input value, including vset.
- R2: When `vill_i` is 1 and `is_vset_i` is 0, `illegal_o` is 1. When `is_vset_i` is 1, `vill_i` has no effect.
- R3: When `vstart_i` is nonzero, `illegal_o` is 1 unless `is_vset_i` or `is_mem_i` is 1.
- R4: When `is_vset_i` is 1, `illegal_o` equals `reserved_i`. Every vtype, register, overlap and class-flag check is ignored in that case.
- R5: `vsew_i` codes 0..3 mean SEW 8, 16, 32 and 64. Codes 4..7 are reserved. `vlmul_i` codes 0..3 mean LMUL 1, 2, 4 and 8. Codes 5, 6 and 7 mean LMUL 1/8, 1/4 and 1/2. Code 4 is reserved. A reserved code makes a non-vset instruction illegal.
- R6: A widening or narrowing instruction is illegal when SEW is 64 or LMUL is 8.
- R7: `ext_i` codes 1, 2 and 3 mark a sign-extension that reads a source narrower by 2, 4 or 8 times; code 0 means none. The instruction is illegal when SEW divided by that factor is below 8. It is also illegal when LMUL divided by that factor is below 1/8.
- R8: For a memory access, `mem_eew_i` codes 0..3 mean EEW 8, 16, 32 and 64. The instruction is illegal when EMUL = EEW/SEW*LMUL is below 1/8 or above 8.
- R9: Group size is max(1, LMUL), so a fractional LMUL counts as 1. The destination group size is:
  - 1 for a mask-writing instruction
  - max(1, EMUL) for a memory access
  - max(1, 2*LMUL) for a widening instruction

  The `vs2` group size is max(1, 2*LMUL) for narrowing and max(1, LMUL/factor) for sign-extension. `vd` must be a multiple of its group size. `vs1` and `vs2` must also be multiples of theirs, where the `use_vs*_i` flag is set. Any misalignment is illegal.
- R10: A masked instruction (`is_masked_i`=1) that does not write a mask and has `vd`=0 is illegal.
- R11: Groups occupy [base, base+size-1].
  - Widening: a used source group that overlaps the destination is illegal.
  - Sign-extension: a `vs2` group that overlaps the destination is illegal.
  - Narrowing: a `vs2` group that overlaps the destination is illegal unless `vd`=`vs2`.
  - Mask-writing: a used source that overlaps the destination is illegal unless its base equals `vd`.
- R12: With `REG_OUT`=1, `illegal_o` shows the verdict for the inputs present at the previous rising clock edge. It is 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vd_i | input | 5 | Destination vector register |
| vs1_i | input | 5 | First source vector register |
| vs2_i | input | 5 | Second source vector register |
| use_vs1_i | input | 1 | vs1 is read as a vector group |
| use_vs2_i | input | 1 | vs2 is read as a vector group |
| reserved_i | input | 1 | Decoder found a reserved encoding |
| is_vset_i | input | 1 | Vector configuration instruction |
| is_mem_i | input | 1 | Vector memory access |
| is_widen_i | input | 1 | Widening instruction |
| is_narrow_i | input | 1 | Narrowing instruction |
| is_mask_dst_i | input | 1 | Destination is a mask register |
| is_masked_i | input | 1 | Uses v0 as mask |
| ext_i | input | 2 | Sign-extension factor code |
| mem_eew_i | input | 2 | Memory element width code |
| vill_i | input | 1 | vtype illegal bit |
| vsew_i | input | 3 | SEW code |
| vlmul_i | input | 3 | LMUL code |
| vstart_i | input | 8 | Current vstart |
| illegal_o | output | 1 | Illegal-instruction verdict |

## Verification
Random stimulus draws one class flag per instruction and a random vtype. Register numbers are half the time rounded down to multiples of 8, so that clean instructions appear alongside misaligned and overlapping ones. Directed cases then separate rules that random traffic tends to mask:
- vset with every fault present except a reserved encoding, against the same instruction with a reserved encoding
- a memory access with nonzero `vstart`, against an arithmetic one
- a narrowing instruction with `vd`=`vs2`, against the same with `vd` one group higher
- fractional-LMUL alignment
- EMUL just inside and just outside its bounds

A transition from a legal to an illegal instruction confirms the one-cycle delay of the registered output.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  parameter int unsigned REG_W = 5;

  typedef logic [REG_W-1:0] vreg_t;
  typedef logic [REG_W:0]   vreg_ext_t;
  typedef logic signed [4:0] lg_t;   // log2 of a multiplier, signed
  typedef logic [1:0]       grp_t;   // log2 of group size, 0..3

  // LMUL code to log2; reserved code 4 maps to 0 and is flagged elsewhere
  function automatic lg_t lmul_lg(input logic [2:0] code);
    if (code == 3'd4) return lg_t'(0);
    return lg_t'({{2{code[2]}}, code});
  endfunction

  function automatic grp_t grp_of(input lg_t l);
    if (l <= lg_t'(0)) return grp_t'(0);
    if (l >= lg_t'(3)) return grp_t'(3);
    return grp_t'(l[1:0]);
  endfunction

  function automatic logic misaligned(input vreg_t r, input grp_t g);
    vreg_t m;
    m = (vreg_t'(1) << g) - vreg_t'(1);
    return |(r & m);
  endfunction

  function automatic logic grp_ovl(input vreg_t a, input grp_t ga,
                                   input vreg_t b, input grp_t gb);
    vreg_ext_t ae, be;
    ae = vreg_ext_t'(a) + (vreg_ext_t'(1) << ga);
    be = vreg_ext_t'(b) + (vreg_ext_t'(1) << gb);
    return (vreg_ext_t'(a) < be) && (vreg_ext_t'(b) < ae);
  endfunction
endpackage

// File: rtl/vlc_vtype_chk.sv
module vlc_vtype_chk
  import vlc_pkg::*;
#(
  parameter int unsigned VSTART_W = 8
) (
  input  logic                vill_i,
  input  logic [2:0]          vsew_i,
  input  logic [2:0]          vlmul_i,
  input  logic [VSTART_W-1:0] vstart_i,
  input  logic [1:0]          ext_i,
  input  logic [1:0]          mem_eew_i,
  input  logic                is_mem_i,
  input  logic                is_widen_i,
  input  logic                is_narrow_i,
  output logic                vill_err_o,
  output logic                vstart_err_o,
  output logic                eew_err_o,
  output logic                emul_err_o,
  output lg_t                 lmul_lg_o,
  output lg_t                 emul_lg_o
);
  lg_t sew_lg, eew_lg, ext_lg, src_lg, emul_lg;
  logic wn;

  assign lmul_lg_o = lmul_lg(vlmul_i);
  assign sew_lg    = lg_t'({2'b00, vsew_i});
  assign eew_lg    = lg_t'({3'b000, mem_eew_i});
  assign ext_lg    = lg_t'({3'b000, ext_i});
  assign src_lg    = lmul_lg_o - ext_lg;
  assign emul_lg   = eew_lg - sew_lg + lmul_lg_o;
  assign emul_lg_o = emul_lg;
  assign wn        = is_widen_i | is_narrow_i;

  assign vill_err_o   = vill_i;
  assign vstart_err_o = (vstart_i != '0) && !is_mem_i;

  // R5 reserved SEW, R6 SEW=64 doubling, R7 extension source below 8 bits
  assign eew_err_o = vsew_i[2]
                   | (wn && vsew_i == 3'd3)
                   | ((ext_i != 2'd0) && (vsew_i < {1'b0, ext_i}));

  // R5 reserved LMUL, R6 doubled LMUL over 8, R7/R8 EMUL outside [1/8, 8]
  assign emul_err_o = (vlmul_i == 3'd4)
                    | (wn && lmul_lg_o == lg_t'(3))
                    | ((ext_i != 2'd0) && (src_lg < lg_t'(-3)))
                    | (is_mem_i && ((emul_lg > lg_t'(3)) || (emul_lg < lg_t'(-3))));
endmodule

// File: rtl/vlc_group_chk.sv
module vlc_group_chk
  import vlc_pkg::*;
(
  input  lg_t        lmul_lg_i,
  input  lg_t        emul_lg_i,
  input  logic [1:0] ext_i,
  input  logic       is_mask_dst_i,
  input  logic       is_mem_i,
  input  logic       is_widen_i,
  input  logic       is_narrow_i,
  input  vreg_t      vd_i,
  input  vreg_t      vs1_i,
  input  vreg_t      vs2_i,
  input  logic       use_vs1_i,
  input  logic       use_vs2_i,
  output logic       align_err_o,
  output grp_t       vd_g_o,
  output grp_t       vs1_g_o,
  output grp_t       vs2_g_o
);
  lg_t wide_lg, ext_lg, src_lg;
  grp_t base_g;

  assign wide_lg = lmul_lg_i + lg_t'(1);
  assign ext_lg  = lg_t'({3'b000, ext_i});
  assign src_lg  = lmul_lg_i - ext_lg;
  assign base_g  = grp_of(lmul_lg_i);

  always_comb begin
    if (is_mask_dst_i)   vd_g_o = grp_t'(0);
    else if (is_mem_i)   vd_g_o = grp_of(emul_lg_i);
    else if (is_widen_i) vd_g_o = grp_of(wide_lg);
    else                 vd_g_o = base_g;

    if (is_narrow_i)         vs2_g_o = grp_of(wide_lg);
    else if (ext_i != 2'd0)  vs2_g_o = grp_of(src_lg);
    else                     vs2_g_o = base_g;

    vs1_g_o = base_g;
  end

  assign align_err_o = misaligned(vd_i, vd_g_o)
                     | (use_vs1_i && misaligned(vs1_i, vs1_g_o))
                     | (use_vs2_i && misaligned(vs2_i, vs2_g_o));
endmodule

// File: rtl/vlc_overlap_chk.sv
module vlc_overlap_chk
  import vlc_pkg::*;
(
  input  vreg_t      vd_i,
  input  vreg_t      vs1_i,
  input  vreg_t      vs2_i,
  input  logic       use_vs1_i,
  input  logic       use_vs2_i,
  input  grp_t       vd_g_i,
  input  grp_t       vs1_g_i,
  input  grp_t       vs2_g_i,
  input  logic       is_widen_i,
  input  logic       is_narrow_i,
  input  logic [1:0] ext_i,
  input  logic       is_mask_dst_i,
  input  logic       is_masked_i,
  output logic       v0_err_o,
  output logic       ovl_err_o
);
  logic ov1, ov2, same1, same2;

  assign ov1   = use_vs1_i && grp_ovl(vd_i, vd_g_i, vs1_i, vs1_g_i);
  assign ov2   = use_vs2_i && grp_ovl(vd_i, vd_g_i, vs2_i, vs2_g_i);
  assign same1 = (vd_i == vs1_i);
  assign same2 = (vd_i == vs2_i);

  // destination group containing v0 starts at v0 once aligned
  assign v0_err_o = is_masked_i && !is_mask_dst_i && (vd_i == '0);

  always_comb begin
    ovl_err_o = 1'b0;
    if (is_widen_i)         ovl_err_o = ov1 | ov2;
    else if (is_narrow_i)   ovl_err_o = ov2 && !same2;
    else if (ext_i != 2'd0) ovl_err_o = ov2;
    else if (is_mask_dst_i) ovl_err_o = (ov1 && !same1) | (ov2 && !same2);
  end
endmodule

// File: rtl/vec_legal_chk.sv
module vec_legal_chk
  import vlc_pkg::*;
#(
  parameter int unsigned VSTART_W = 8,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4:0]          vd_i,
  input  logic [4:0]          vs1_i,
  input  logic [4:0]          vs2_i,
  input  logic                use_vs1_i,
  input  logic                use_vs2_i,
  input  logic                reserved_i,
  input  logic                is_vset_i,
  input  logic                is_mem_i,
  input  logic                is_widen_i,
  input  logic                is_narrow_i,
  input  logic                is_mask_dst_i,
  input  logic                is_masked_i,
  input  logic [1:0]          ext_i,
  input  logic [1:0]          mem_eew_i,
  input  logic                vill_i,
  input  logic [2:0]          vsew_i,
  input  logic [2:0]          vlmul_i,
  input  logic [VSTART_W-1:0] vstart_i,
  output logic                illegal_o
);
  localparam int unsigned N_CAUSE = 8;

  logic vill_err, vstart_err, eew_err, emul_err, align_err, v0_err, ovl_err;
  lg_t  lmul_lg_w, emul_lg_w;
  grp_t vd_g, vs1_g, vs2_g;
  logic [N_CAUSE-1:0] cause;
  logic verdict;

  vlc_vtype_chk #(.VSTART_W(VSTART_W)) u_vtype (
    .vill_i       (vill_i),
    .vsew_i       (vsew_i),
    .vlmul_i      (vlmul_i),
    .vstart_i     (vstart_i),
    .ext_i        (ext_i),
    .mem_eew_i    (mem_eew_i),
    .is_mem_i     (is_mem_i),
    .is_widen_i   (is_widen_i),
    .is_narrow_i  (is_narrow_i),
    .vill_err_o   (vill_err),
    .vstart_err_o (vstart_err),
    .eew_err_o    (eew_err),
    .emul_err_o   (emul_err),
    .lmul_lg_o    (lmul_lg_w),
    .emul_lg_o    (emul_lg_w)
  );

  vlc_group_chk u_group (
    .lmul_lg_i     (lmul_lg_w),
    .emul_lg_i     (emul_lg_w),
    .ext_i         (ext_i),
    .is_mask_dst_i (is_mask_dst_i),
    .is_mem_i      (is_mem_i),
    .is_widen_i    (is_widen_i),
    .is_narrow_i   (is_narrow_i),
    .vd_i          (vd_i),
    .vs1_i         (vs1_i),
    .vs2_i         (vs2_i),
    .use_vs1_i     (use_vs1_i),
    .use_vs2_i     (use_vs2_i),
    .align_err_o   (align_err),
    .vd_g_o        (vd_g),
    .vs1_g_o       (vs1_g),
    .vs2_g_o       (vs2_g)
  );

  vlc_overlap_chk u_overlap (
    .vd_i          (vd_i),
    .vs1_i         (vs1_i),
    .vs2_i         (vs2_i),
    .use_vs1_i     (use_vs1_i),
    .use_vs2_i     (use_vs2_i),
    .vd_g_i        (vd_g),
    .vs1_g_i       (vs1_g),
    .vs2_g_i       (vs2_g),
    .is_widen_i    (is_widen_i),
    .is_narrow_i   (is_narrow_i),
    .ext_i         (ext_i),
    .is_mask_dst_i (is_mask_dst_i),
    .is_masked_i   (is_masked_i),
    .v0_err_o      (v0_err),
    .ovl_err_o     (ovl_err)
  );

  // vset escapes all but the reserved-encoding cause
  assign cause = {reserved_i,
                  {(N_CAUSE-1){!is_vset_i}} &
                  {vill_err, vstart_err, eew_err, emul_err, align_err, v0_err, ovl_err}};
  assign verdict = |cause;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) illegal_o <= 1'b0;
        else         illegal_o <= verdict;
      end

      // R1
      reserved_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reserved_i |=> illegal_o);
      // R2
      vill_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vill_i && !is_vset_i) |=> illegal_o);
      // R3
      vstart_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((vstart_i != '0) && !is_vset_i && !is_mem_i) |=> illegal_o);
      // R4
      vset_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_vset_i && !reserved_i) |=> !illegal_o);
      // R10
      v0_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_masked_i && !is_vset_i && !is_mask_dst_i && vd_i == 5'd0) |=> illegal_o);
    end else begin : g_comb
      assign illegal_o = verdict;

      // R1
      reserved_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reserved_i |-> illegal_o);
      // R2
      vill_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vill_i && !is_vset_i) |-> illegal_o);
      // R3
      vstart_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((vstart_i != '0) && !is_vset_i && !is_mem_i) |-> illegal_o);
      // R4
      vset_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_vset_i && !reserved_i) |-> !illegal_o);
      // R10
      v0_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_masked_i && !is_vset_i && !is_mask_dst_i && vd_i == 5'd0) |-> illegal_o);
    end
  endgenerate
endmodule

// File: tb/sim_vec_legal_chk.sv
`timescale 1ns/1ps
module sim_vec_legal_chk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] vd, vs1, vs2;
  logic use1, use2, rsv, vset, mem, widen, narrow, mdst, masked, vill;
  logic [1:0] ext, eew;
  logic [2:0] vsew, vlmul;
  logic [7:0] vstart;
  logic illegal;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_legal_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2),
    .use_vs1_i(use1), .use_vs2_i(use2), .reserved_i(rsv), .is_vset_i(vset),
    .is_mem_i(mem), .is_widen_i(widen), .is_narrow_i(narrow),
    .is_mask_dst_i(mdst), .is_masked_i(masked), .ext_i(ext), .mem_eew_i(eew),
    .vill_i(vill), .vsew_i(vsew), .vlmul_i(vlmul), .vstart_i(vstart),
    .illegal_o(illegal)
  );

  function automatic int grp(input int x8);
    return (x8 <= 8) ? 1 : x8 / 8;
  endfunction

  function automatic bit ovl(input int a, input int ga, input int b, input int gb);
    return (a < b + gb) && (b < a + ga);
  endfunction

  function automatic bit expect_illegal();
    int sew, l8, k, ew, e8, gd, g1, g2;
    if (rsv) return 1;
    if (vset) return 0;
    if (vill) return 1;
    if (vstart != 0 && !mem) return 1;
    if (vsew > 3 || vlmul == 4) return 1;
    sew = 8 << vsew;
    case (vlmul)
      3'd0: l8 = 8;  3'd1: l8 = 16; 3'd2: l8 = 32; 3'd3: l8 = 64;
      3'd5: l8 = 1;  3'd6: l8 = 2;  default: l8 = 4;
    endcase
    k = 1 << ext;
    if ((widen || narrow) && (sew == 64 || l8 == 64)) return 1;
    if (ext != 0 && (sew / k < 8 || l8 < k)) return 1;
    ew = 8 << eew;
    e8 = 0;
    if (mem) begin
      if (l8 * ew < sew || l8 * ew > 64 * sew) return 1;
      e8 = l8 * ew / sew;
    end
    g1 = grp(l8);
    gd = mdst ? 1 : mem ? grp(e8) : widen ? grp(2 * l8) : g1;
    g2 = narrow ? grp(2 * l8) : (ext != 0) ? grp(l8 / k) : g1;
    if (vd % gd != 0) return 1;
    if (use1 && vs1 % g1 != 0) return 1;
    if (use2 && vs2 % g2 != 0) return 1;
    if (masked && !mdst && vd == 0) return 1;
    if (widen && ((use1 && ovl(vd, gd, vs1, g1)) || (use2 && ovl(vd, gd, vs2, g2)))) return 1;
    if (narrow && use2 && ovl(vd, gd, vs2, g2) && vd != vs2) return 1;
    if (ext != 0 && !widen && !narrow && use2 && ovl(vd, gd, vs2, g2)) return 1;
    if (mdst && !widen && !narrow && ext == 0 &&
        ((use1 && ovl(vd, gd, vs1, g1) && vd != vs1) ||
         (use2 && ovl(vd, gd, vs2, g2) && vd != vs2))) return 1;
    return 0;
  endfunction

  task automatic clear_in();
    vd = 5'd8; vs1 = 5'd16; vs2 = 5'd24; use1 = 1; use2 = 1;
    rsv = 0; vset = 0; mem = 0; widen = 0; narrow = 0; mdst = 0; masked = 0;
    ext = 0; eew = 0; vill = 0; vsew = 3'd1; vlmul = 3'd0; vstart = 0;
  endtask

  task automatic check(input string req, input bit exp);
    checks++;
    if (illegal !== exp) begin
      errors++;
      $display("FAIL %s: illegal_o=%0b expected %0b (vd=%0d vs1=%0d vs2=%0d sew=%0d lmul=%0d)",
               req, illegal, exp, vd, vs1, vs2, vsew, vlmul);
    end
  endtask

  // inputs are set at a falling edge; verdict appears after the next rising edge
  task automatic run(input string req);
    bit exp;
    exp = expect_illegal();
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic rand_in();
    int cls;
    clear_in();
    vd  = 5'($urandom_range(0, 31));
    vs1 = 5'($urandom_range(0, 31));
    vs2 = 5'($urandom_range(0, 31));
    if ($urandom_range(0, 1) == 0) begin
      vd = vd & 5'h18; vs1 = vs1 & 5'h18; vs2 = vs2 & 5'h18;
    end
    use1 = 1'($urandom_range(0, 1));
    use2 = 1'($urandom_range(0, 1));
    rsv  = ($urandom_range(0, 19) == 0);
    vill = ($urandom_range(0, 9) == 0);
    vstart = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(1, 255)) : 8'd0;
    vsew  = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
    vlmul = 3'($urandom_range(0, 7));
    masked = 1'($urandom_range(0, 1));
    eew = 2'($urandom_range(0, 3));
    cls = $urandom_range(0, 6);
    case (cls)
      0: vset = 1;
      1: mem = 1;
      2: widen = 1;
      3: narrow = 1;
      4: ext = 2'($urandom_range(1, 3));
      5: mdst = 1;
      default: ;
    endcase
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    clear_in();
    rsv = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (illegal !== 1'b0) begin
      errors++;
      $display("FAIL R12: illegal_o=%0b during reset expected 0", illegal);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R12 one-cycle delay: legal then illegal, old value still visible before edge
    clear_in(); run("R12 legal baseline");
    rsv = 1; #1; check("R12 output holds until clock edge", 1'b0);
    @(negedge clk); check("R12 registered verdict", 1'b1);

    clear_in(); rsv = 1; vset = 1; run("R1 reserved on vset");
    clear_in(); vill = 1; run("R2 vill on arithmetic");
    clear_in(); vset = 1; vill = 1; vstart = 8'd5; vsew = 3'd6; vlmul = 3'd4;
      vd = 5'd3; masked = 1; run("R4 vset exempt from all checks");
    clear_in(); vstart = 8'd1; run("R3 vstart nonzero arithmetic");
    clear_in(); vstart = 8'd200; mem = 1; eew = 2'd1; run("R3 vstart nonzero memory exempt");
    clear_in(); vsew = 3'd5; run("R5 reserved SEW code");
    clear_in(); vlmul = 3'd4; run("R5 reserved LMUL code");
    clear_in(); widen = 1; vsew = 3'd3; run("R6 widen at SEW 64");
    clear_in(); narrow = 1; vlmul = 3'd3; vd = 5'd0; vs2 = 5'd8; run("R6 narrow at LMUL 8");
    clear_in(); ext = 2'd3; vsew = 3'd2; use1 = 0; run("R7 vf8 from SEW 32");
    clear_in(); ext = 2'd1; vsew = 3'd3; vlmul = 3'd5; use1 = 0; run("R7 source LMUL below 1/8");
    clear_in(); mem = 1; vsew = 3'd0; eew = 2'd3; vlmul = 3'd3; vd = 5'd0; run("R8 EMUL 64 over limit");
    clear_in(); mem = 1; vsew = 3'd0; eew = 2'd3; vlmul = 3'd2; vd = 5'd0; run("R8 EMUL 32 wait 8? check");
    clear_in(); mem = 1; vsew = 3'd3; eew = 2'd0; vlmul = 3'd6; run("R8 EMUL 1/32 under limit");
    clear_in(); mem = 1; vsew = 3'd3; eew = 2'd0; vlmul = 3'd0; run("R8 EMUL 1/8 at limit");
    clear_in(); vlmul = 3'd1; vd = 5'd9; run("R9 vd misaligned LMUL 2");
    clear_in(); vlmul = 3'd7; vd = 5'd9; vs1 = 5'd3; vs2 = 5'd5; run("R9 fractional LMUL aligns to 1");
    clear_in(); widen = 1; vlmul = 3'd1; vd = 5'd2; vs1 = 5'd8; vs2 = 5'd10; run("R9 widen dest needs 4");
    clear_in(); masked = 1; vd = 5'd0; run("R10 masked write to v0");
    clear_in(); masked = 1; mdst = 1; vd = 5'd0; run("R10 mask destination exempt");
    clear_in(); narrow = 1; vlmul = 3'd1; vd = 5'd8; vs2 = 5'd8; use1 = 0; run("R11 narrow vd equals vs2");
    clear_in(); narrow = 1; vlmul = 3'd1; vd = 5'd10; vs2 = 5'd8; use1 = 0; run("R11 narrow partial overlap");
    clear_in(); widen = 1; vlmul = 3'd0; vd = 5'd8; vs1 = 5'd9; vs2 = 5'd16; run("R11 widen source in dest");
    clear_in(); mdst = 1; vlmul = 3'd1; vd = 5'd9; vs1 = 5'd8; vs2 = 5'd16; run("R11 mask dest inside source");

    for (int i = 0; i < 4000; i++) begin
      rand_in();
      run("R1-R12 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule